// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block sits next to a processor core and takes care of getting into a handler. In an idle cycle it looks at three request sources: a synchronous exception carrying a vector number, a fast interrupt, and a normal interrupt carrying a number and a priority level. It decides whether one of them can be accepted under the current status word. If one is accepted, the block snapshots the status word and the program counter. It then moves the live stack pointer (R0) into the user or the interrupt stack pointer and runs the entry sequence for that kind of request.

A fast interrupt saves the PC and the status word into backup registers and jumps to a fixed vector register, with no memory traffic. A normal interrupt or an exception first pushes the status word onto the interrupt stack and then pushes the PC. It then reads the handler address from a vector table through a single-port 32-bit memory port with a valid/ready handshake. When the sequence ends the block raises a one-cycle done flag. Along with it the block presents the new PC, the new status word and both stack pointers. The core copies the new interrupt stack pointer into R0 and leaves any sleep state on that flag.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset, `done`, `ack` and `mem_valid` are low and the block is idle.
- R2: A normal interrupt is accepted only when the I flag (status bit 16) is 1 and the current IPL (status bits 27:24) is strictly lower than `nirq_lvl`. Otherwise the request has no effect: no memory access, no `ack` and no `done`.
- R3: A fast interrupt is accepted only when the I flag is 1 and the current IPL is not 15. When both interrupt types are acceptable, the fast one is taken.
- R4: A pending exception is accepted in any idle cycle, whatever I and IPL are, and it wins over both interrupt types.
- R5: At entry, when U (status bit 17) is 1, `new_usp` takes R0 and the interrupt stack starts from `cur_isp`. When U is 0, `new_usp` keeps `cur_usp` and the interrupt stack starts from R0.
- R6: `new_psw` is the status snapshot with PM (bit 20), I and U cleared. Its IPL field is 15 for a fast interrupt, the accepted level for a normal interrupt, and unchanged for an exception.
- R7: Fast path: `bk_pc` is the entry PC and `bk_psw` is the snapshot. `new_pc` is `fast_vec`. No memory access occurs, and `done` is high in the first cycle after the accepting edge.
- R8: Normal and exception paths write the snapshot status to start-4 and then the entry PC to start-8. `new_isp` is start-8, where start is the interrupt stack start of R5.
- R9: After the two pushes, one read fetches `new_pc`. The read address is `tbl_base + 4*num` for a normal interrupt. For an exception with a vector below 0x100 it is `0xFFFFFFC0 + 4*vec`, and for other vectors it is `tbl_base + 4*vec[7:0]`. All address sums wrap at 32 bits.
- R10: A memory request holds `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready`, and the sequence does not advance without it.
- R11: `done` is high for exactly one cycle per sequence. `done_kind` reports 1 for an exception, 2 for a normal interrupt and 3 for a fast interrupt. Input changes while a sequence runs do not alter its results.
- R12: An accepted interrupt gives one `ack` pulse in the cycle after the accepting edge. `ack_num` is the accepted number for a normal interrupt, and `ack_fast` is 1 for a fast one. Exceptions give no `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nirq_req | input | 1 | Normal interrupt pending |
| nirq_num | input | NUM_W | Normal interrupt number |
| nirq_lvl | input | IPL_W | Normal interrupt priority level |
| fint_req | input | 1 | Fast interrupt pending |
| exc_req | input | 1 | Synchronous exception pending |
| exc_vec | input | VEC_W | Exception vector number |
| cur_psw | input | XLEN | Current packed status word |
| cur_pc | input | XLEN | PC to return to |
| cur_r0 | input | XLEN | Live stack pointer R0 |
| cur_usp | input | XLEN | Current user stack pointer |
| cur_isp | input | XLEN | Current interrupt stack pointer |
| tbl_base | input | XLEN | Relocatable vector table base |
| fast_vec | input | XLEN | Fast interrupt handler address |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | XLEN | Memory byte address |
| mem_wdata | output | XLEN | Memory write data |
| mem_rdata | input | XLEN | Memory read data |
| mem_ready | input | 1 | Memory accepts the request |
| new_pc | output | XLEN | Handler address |
| new_psw | output | XLEN | Status word for the handler |
| new_usp | output | XLEN | Updated user stack pointer |
| new_isp | output | XLEN | Updated interrupt stack pointer, also the new R0 |
| bk_pc | output | XLEN | Fast-path backup PC |
| bk_psw | output | XLEN | Fast-path backup status word |
| ack | output | 1 | Interrupt acknowledge pulse |
| ack_fast | output | 1 | Acknowledge refers to the fast interrupt |
| ack_num | output | NUM_W | Acknowledged interrupt number |
| done | output | 1 | Entry sequence complete, one cycle |
| done_kind | output | 2 | Kind of request completed |

## Verification
The bench builds the block with its defaults: 4-bit priority levels, 8-bit interrupt numbers and 9-bit exception vectors. With these values a sweep covers the whole 16 by 16 grid of current IPL against requested level, with the I flag both clear and set. This reaches every accept and reject boundary, including level equality and the IPL 15 ceiling for fast interrupts. The 9-bit vector gives both exception address forms, and the sweep includes the wrap of the fixed 0xFFFFFFC0 base. The memory model varies its ready latency from zero to two cycles, so the hold and wait behaviour of every access is exercised.

// File: rtl/irq_entry_pkg.sv
// irq_entry_pkg: shared types and status word field positions for the
// interrupt entry sequencer. Field positions are fixed because the core
// decodes the packed status word with the same layout.
package irq_entry_pkg;

    // Status word field positions
    localparam int PSW_I_BIT   = 16;
    localparam int PSW_U_BIT   = 17;
    localparam int PSW_PM_BIT  = 20;
    localparam int PSW_IPL_LSB = 24;

    // Kind of request that the sequencer is servicing
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_EXC  = 2'd1,
        KIND_NORM = 2'd2,
        KIND_FAST = 2'd3
    } entry_kind_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_SR = 3'd1,
        ST_PUSH_PC = 3'd2,
        ST_FETCH   = 3'd3,
        ST_DONE    = 3'd4
    } entry_state_e;

endpackage

// File: rtl/irq_accept.sv
// irq_accept: combinational acceptance decision for one idle cycle.
// Assumes the caller only uses the result while idle. Priority is
// exception, then fast interrupt, then normal interrupt.
module irq_accept
    import irq_entry_pkg::*;
#(
    parameter int IPL_W = 4
) (
    input  logic             exc_req,
    input  logic             fint_req,
    input  logic             nirq_req,
    input  logic [IPL_W-1:0] nirq_lvl,
    input  logic             flag_i,
    input  logic [IPL_W-1:0] cur_ipl,
    output entry_kind_e      kind
);

    localparam logic [IPL_W-1:0] TOP_IPL = {IPL_W{1'b1}};

    logic fast_ok;
    logic norm_ok;

    // Gate each interrupt type by the enable flag and the priority mask
    always_comb begin
        fast_ok = fint_req && flag_i && (cur_ipl != TOP_IPL);
        norm_ok = nirq_req && flag_i && (cur_ipl < nirq_lvl);
    end

    // Pick the winner by fixed priority
    always_comb begin
        if (exc_req)      kind = KIND_EXC;
        else if (fast_ok) kind = KIND_FAST;
        else if (norm_ok) kind = KIND_NORM;
        else              kind = KIND_NONE;
    end

endmodule

// File: rtl/irq_vec_addr.sv
// irq_vec_addr: byte address of the vector table entry to fetch.
// Normal interrupts index the relocatable table by number. Exceptions
// below 256 index a fixed base; higher ones index the relocatable table
// by their low 8 bits. Assumes VEC_W >= 8.
module irq_vec_addr
    import irq_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NUM_W    = 8,
    parameter int          VEC_W    = 9,
    parameter logic [31:0] EXC_BASE = 32'hFFFF_FFC0
) (
    input  entry_kind_e      kind,
    input  logic [NUM_W-1:0] num,
    input  logic [VEC_W-1:0] vec,
    input  logic [XLEN-1:0]  tbl_base,
    output logic [XLEN-1:0]  addr
);

    localparam logic [XLEN-1:0] FIX_BASE = XLEN'(EXC_BASE);

    logic            vec_low;
    logic [7:0]      vec_idx;
    logic [XLEN-1:0] num_off;
    logic [XLEN-1:0] vec_off;

    // Decide whether the vector belongs to the fixed range
    generate
        if (VEC_W > 8) begin : g_wide_vec
            assign vec_low = (vec[VEC_W-1:8] == '0);
        end else begin : g_narrow_vec
            assign vec_low = 1'b1;
        end
    endgenerate

    assign vec_idx = vec[7:0];

    // Scale indices to word offsets
    always_comb begin
        num_off = XLEN'(num) << 2;
        vec_off = XLEN'(vec_idx) << 2;
    end

    // Select the base and offset for the current kind
    always_comb begin
        if (kind == KIND_EXC) begin
            addr = vec_low ? (FIX_BASE + vec_off) : (tbl_base + vec_off);
        end else begin
            addr = tbl_base + num_off;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
// irq_entry_seq: interrupt and exception entry sequencer.
// In an idle cycle it accepts at most one request, snapshots status and PC,
// and settles the stack pointers. The fast path loads backup registers and
// a fixed vector. The other paths push status then PC on the interrupt stack
// and fetch the handler address through a valid/ready memory port. Assumes
// the memory port completes every request eventually. New requests are not
// looked at until the sequence has finished.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NUM_W    = 8,
    parameter int          IPL_W    = 4,
    parameter int          VEC_W    = 9,
    parameter logic [31:0] EXC_BASE = 32'hFFFF_FFC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nirq_req,
    input  logic [NUM_W-1:0] nirq_num,
    input  logic [IPL_W-1:0] nirq_lvl,
    input  logic             fint_req,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic [XLEN-1:0]  cur_psw,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_r0,
    input  logic [XLEN-1:0]  cur_usp,
    input  logic [XLEN-1:0]  cur_isp,
    input  logic [XLEN-1:0]  tbl_base,
    input  logic [XLEN-1:0]  fast_vec,
    output logic             mem_valid,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready,
    output logic [XLEN-1:0]  new_pc,
    output logic [XLEN-1:0]  new_psw,
    output logic [XLEN-1:0]  new_usp,
    output logic [XLEN-1:0]  new_isp,
    output logic [XLEN-1:0]  bk_pc,
    output logic [XLEN-1:0]  bk_psw,
    output logic             ack,
    output logic             ack_fast,
    output logic [NUM_W-1:0] ack_num,
    output logic             done,
    output logic [1:0]       done_kind
);

    localparam logic [IPL_W-1:0] TOP_IPL   = {IPL_W{1'b1}};
    localparam logic [XLEN-1:0]  WORD_STEP = XLEN'(4);

    entry_state_e     state_q;
    entry_kind_e      kind_q;
    entry_kind_e      pick;
    logic [XLEN-1:0]  snap_psw_q;
    logic [XLEN-1:0]  snap_pc_q;
    logic [XLEN-1:0]  isp_q;
    logic [XLEN-1:0]  usp_q;
    logic [XLEN-1:0]  tbl_q;
    logic [NUM_W-1:0] num_q;
    logic [IPL_W-1:0] lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic [XLEN-1:0]  pc_q;
    logic [XLEN-1:0]  bk_pc_q;
    logic [XLEN-1:0]  bk_psw_q;
    logic             ack_q;
    logic             ack_fast_q;
    logic [NUM_W-1:0] ack_num_q;
    logic [XLEN-1:0]  vec_addr;
    logic             hs;
    logic             entering;
    logic             live_u;

    assign live_u   = cur_psw[PSW_U_BIT];
    assign hs       = mem_valid && mem_ready;
    assign entering = (state_q == ST_IDLE) && (pick != KIND_NONE);

    irq_accept #(
        .IPL_W (IPL_W)
    ) u_accept (
        .exc_req  (exc_req),
        .fint_req (fint_req),
        .nirq_req (nirq_req),
        .nirq_lvl (nirq_lvl),
        .flag_i   (cur_psw[PSW_I_BIT]),
        .cur_ipl  (cur_psw[PSW_IPL_LSB +: IPL_W]),
        .kind     (pick)
    );

    irq_vec_addr #(
        .XLEN     (XLEN),
        .NUM_W    (NUM_W),
        .VEC_W    (VEC_W),
        .EXC_BASE (EXC_BASE)
    ) u_vaddr (
        .kind     (kind_q),
        .num      (num_q),
        .vec      (vec_q),
        .tbl_base (tbl_q),
        .addr     (vec_addr)
    );

    // Sequencer state and step control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (entering) begin
                        kind_q  <= pick;
                        state_q <= (pick == KIND_FAST) ? ST_DONE : ST_PUSH_SR;
                    end
                end
                ST_PUSH_SR: if (hs) state_q <= ST_PUSH_PC;
                ST_PUSH_PC: if (hs) state_q <= ST_FETCH;
                ST_FETCH:   if (hs) state_q <= ST_DONE;
                ST_DONE:    state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Snapshot of the request and context at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_psw_q <= '0;
            snap_pc_q  <= '0;
            usp_q      <= '0;
            tbl_q      <= '0;
            num_q      <= '0;
            lvl_q      <= '0;
            vec_q      <= '0;
        end else if (entering) begin
            snap_psw_q <= cur_psw;
            snap_pc_q  <= cur_pc;
            usp_q      <= live_u ? cur_r0 : cur_usp;
            tbl_q      <= tbl_base;
            num_q      <= nirq_num;
            lvl_q      <= nirq_lvl;
            vec_q      <= exc_vec;
        end
    end

    // Interrupt stack pointer: seeded at entry, stepped down per push
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isp_q <= '0;
        end else if (entering) begin
            isp_q <= live_u ? cur_isp : cur_r0;
        end else if (hs && mem_we) begin
            isp_q <= isp_q - WORD_STEP;
        end
    end

    // Handler address and fast-path backup registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            bk_pc_q  <= '0;
            bk_psw_q <= '0;
        end else if (entering && (pick == KIND_FAST)) begin
            pc_q     <= fast_vec;
            bk_pc_q  <= cur_pc;
            bk_psw_q <= cur_psw;
        end else if ((state_q == ST_FETCH) && hs) begin
            pc_q <= mem_rdata;
        end
    end

    // Acknowledge pulse for accepted interrupts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q      <= 1'b0;
            ack_fast_q <= 1'b0;
            ack_num_q  <= '0;
        end else begin
            ack_q      <= entering && (pick != KIND_EXC);
            ack_fast_q <= entering && (pick == KIND_FAST);
            if (entering && (pick == KIND_NORM)) ack_num_q <= nirq_num;
            else if (entering)                    ack_num_q <= '0;
        end
    end

    // Memory request for the current step
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_PUSH_SR: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = isp_q - WORD_STEP;
                mem_wdata = snap_psw_q;
            end
            ST_PUSH_PC: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = isp_q - WORD_STEP;
                mem_wdata = snap_pc_q;
            end
            ST_FETCH: begin
                mem_valid = 1'b1;
                mem_addr  = vec_addr;
            end
            default: ;
        endcase
    end

    // Handler status word: privilege flags cleared, level set per kind
    always_comb begin
        new_psw = snap_psw_q;
        new_psw[PSW_I_BIT]  = 1'b0;
        new_psw[PSW_U_BIT]  = 1'b0;
        new_psw[PSW_PM_BIT] = 1'b0;
        if (kind_q == KIND_FAST)      new_psw[PSW_IPL_LSB +: IPL_W] = TOP_IPL;
        else if (kind_q == KIND_NORM) new_psw[PSW_IPL_LSB +: IPL_W] = lvl_q;
    end

    assign new_pc    = pc_q;
    assign new_usp   = usp_q;
    assign new_isp   = isp_q;
    assign bk_pc     = bk_pc_q;
    assign bk_psw    = bk_psw_q;
    assign ack       = ack_q;
    assign ack_fast  = ack_fast_q;
    assign ack_num   = ack_num_q;
    assign done      = (state_q == ST_DONE);
    assign done_kind = kind_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!done && !ack && !mem_valid)); // R1
    AST_FAST_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == KIND_FAST && state_q != ST_IDLE) |-> !mem_valid); // R7
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_we) |=> (isp_q == $past(isp_q) - WORD_STEP)); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_we) && $stable(mem_wdata))); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R12
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!new_psw[PSW_I_BIT] && !new_psw[PSW_U_BIT] && !new_psw[PSW_PM_BIT])); // R6
    AST_FAST_TOP_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_kind == KIND_FAST) |-> (new_psw[PSW_IPL_LSB +: IPL_W] == TOP_IPL)); // R6

endmodule

// File: tb/tb_irq_entry_seq.sv
// tb_irq_entry_seq: sweeps acceptance over the full IPL/level grid, the fast
// path against the IPL ceiling, and a set of exception vectors, with a
// memory model whose ready latency varies per trial.
module tb_irq_entry_seq;

    localparam int XLEN = 32;
    localparam int NUM_W = 8;
    localparam int IPL_W = 4;
    localparam int VEC_W = 9;
    localparam logic [31:0] RD_XOR = 32'h3C3C_0000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             nirq_req = 1'b0;
    logic [NUM_W-1:0] nirq_num = '0;
    logic [IPL_W-1:0] nirq_lvl = '0;
    logic             fint_req = 1'b0;
    logic             exc_req = 1'b0;
    logic [VEC_W-1:0] exc_vec = '0;
    logic [XLEN-1:0]  cur_psw = '0, cur_pc = '0, cur_r0 = '0, cur_usp = '0;
    logic [XLEN-1:0]  cur_isp = '0, tbl_base = '0, fast_vec = '0;
    logic             mem_valid, mem_we, mem_ready = 1'b0;
    logic [XLEN-1:0]  mem_addr, mem_wdata, mem_rdata;
    logic [XLEN-1:0]  new_pc, new_psw, new_usp, new_isp, bk_pc, bk_psw;
    logic             ack, ack_fast, done;
    logic [NUM_W-1:0] ack_num;
    logic [1:0]       done_kind;

    always #5 clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .nirq_req(nirq_req), .nirq_num(nirq_num),
        .nirq_lvl(nirq_lvl), .fint_req(fint_req), .exc_req(exc_req), .exc_vec(exc_vec),
        .cur_psw(cur_psw), .cur_pc(cur_pc), .cur_r0(cur_r0), .cur_usp(cur_usp),
        .cur_isp(cur_isp), .tbl_base(tbl_base), .fast_vec(fast_vec),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .new_pc(new_pc), .new_psw(new_psw), .new_usp(new_usp), .new_isp(new_isp),
        .bk_pc(bk_pc), .bk_psw(bk_psw), .ack(ack), .ack_fast(ack_fast),
        .ack_num(ack_num), .done(done), .done_kind(done_kind)
    );

    assign mem_rdata = mem_addr ^ RD_XOR;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: ready after lat wait cycles
    int lat = 0;
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (mem_valid) begin
            if (wait_cnt >= lat) mem_ready <= 1'b1;
            else begin
                mem_ready <= 1'b0;
                wait_cnt  <= wait_cnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
            wait_cnt  <= 0;
        end
    end

    // Monitor: record accesses and acks, check request hold
    int wr_cnt = 0, rd_cnt = 0, ack_cnt = 0;
    logic [31:0] wr_addr [2];
    logic [31:0] wr_data [2];
    logic [31:0] rd_addr_s = '0;
    logic        ack_fast_s = 1'b0;
    logic [NUM_W-1:0] ack_num_s = '0;
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (pend && mem_valid) chk(mem_addr == pend_addr, "R10", mem_addr, pend_addr);
            pend = mem_valid && !mem_ready;
            pend_addr = mem_addr;
            if (ack) begin
                ack_cnt++;
                ack_fast_s = ack_fast;
                ack_num_s  = ack_num;
            end
            if (mem_valid && mem_ready) begin
                wait_cnt <= 0;
                if (mem_we) begin
                    if (wr_cnt < 2) begin
                        wr_addr[wr_cnt] = mem_addr;
                        wr_data[wr_cnt] = mem_wdata;
                    end
                    wr_cnt++;
                end else begin
                    rd_addr_s = mem_addr;
                    rd_cnt++;
                end
            end
        end
    end

    // Trial inputs
    bit t_exc, t_fint, t_nirq, t_i, t_u;
    logic [VEC_W-1:0] t_vec;
    logic [NUM_W-1:0] t_num;
    logic [IPL_W-1:0] t_lvl, t_ipl;
    int trial = 0;

    function automatic logic [31:0] pack_psw(bit fi, bit fu, bit fpm, logic [3:0] ipl);
        logic [31:0] p;
        p = 32'h8000_0A5C;
        p[16] = fi;
        p[17] = fu;
        p[20] = fpm;
        p[27:24] = ipl;
        return p;
    endfunction

    task automatic run_trial();
        int kind;
        logic [31:0] psw_in, pc_in, r0_in, usp_in, isp_in, tb_in, fv_in;
        logic [31:0] start, exp_psw, vaddr, exp_usp;
        bit seen;
        @(negedge clk);
        trial++;
        lat    = trial % 3;
        psw_in = pack_psw(t_i, t_u, trial[0], t_ipl);
        pc_in  = 32'h0040_0000 + trial * 4;
        r0_in  = (trial % 7 == 0) ? 32'h0000_0004 : 32'h0000_8000 + trial * 16;
        usp_in = 32'h2000_0000 + trial;
        isp_in = 32'h0001_0000 + trial * 32;
        tb_in  = 32'h0008_0000 + trial * 1024;
        fv_in  = 32'h00FF_0100 + trial;
        nirq_req = t_nirq; nirq_num = t_num; nirq_lvl = t_lvl;
        fint_req = t_fint; exc_req = t_exc; exc_vec = t_vec;
        cur_psw = psw_in; cur_pc = pc_in; cur_r0 = r0_in; cur_usp = usp_in;
        cur_isp = isp_in; tbl_base = tb_in; fast_vec = fv_in;
        wr_cnt = 0; rd_cnt = 0; ack_cnt = 0;
        // Expected kind from the acceptance rules
        if (t_exc) kind = 1;
        else if (t_fint && t_i && t_ipl != 4'hF) kind = 3;
        else if (t_nirq && t_i && t_ipl < t_lvl) kind = 2;
        else kind = 0;
        start   = t_u ? isp_in : r0_in;
        exp_usp = t_u ? r0_in : usp_in;
        exp_psw = psw_in & ~32'h0013_0000;
        if (kind == 3) exp_psw[27:24] = 4'hF;
        if (kind == 2) exp_psw[27:24] = t_lvl;
        if (kind == 2) vaddr = tb_in + {22'd0, t_num, 2'b00};
        else if (t_vec < 9'h100) vaddr = 32'hFFFF_FFC0 + {21'd0, t_vec, 2'b00};
        else vaddr = tb_in + {22'd0, t_vec[7:0], 2'b00};
        if (kind == 0) begin
            seen = 1'b0;
            repeat (4) begin
                @(negedge clk);
                if (done || mem_valid || ack) seen = 1'b1;
            end
            chk(!seen, t_fint ? "R3" : "R2", {31'd0, seen}, 32'd0);
            nirq_req = 0; fint_req = 0; exc_req = 0;
            return;
        end
        // Scramble everything during the sequence (R11)
        @(negedge clk);
        cur_psw = ~psw_in; cur_pc = 32'hDEAD_0000; cur_r0 = 32'h1111_1110;
        cur_usp = 32'h2222_2220; cur_isp = 32'h3333_3330; tbl_base = 32'h4444_0000;
        fast_vec = 32'h5555_5550; nirq_num = ~t_num; nirq_lvl = ~t_lvl; exc_vec = ~t_vec;
        if (kind == 3) chk(done == 1'b1, "R7", {31'd0, done}, 32'd1);
        seen = done;
        for (int k = 0; k < 60 && !seen; k++) begin
            @(negedge clk);
            seen = done;
        end
        chk(seen, "R11", {31'd0, seen}, 32'd1);
        if (!seen) return;
        chk(done_kind == kind[1:0], kind == 1 ? "R4" : (kind == 3 ? "R3" : "R2"),
            {30'd0, done_kind}, kind);
        chk(new_psw == exp_psw, "R6", new_psw, exp_psw);
        chk(new_usp == exp_usp, "R5", new_usp, exp_usp);
        if (kind == 3) begin
            chk(new_pc == fv_in, "R7", new_pc, fv_in);
            chk(bk_pc == pc_in, "R7", bk_pc, pc_in);
            chk(bk_psw == psw_in, "R7", bk_psw, psw_in);
            chk(wr_cnt + rd_cnt == 0, "R7", wr_cnt + rd_cnt, 0);
            chk(new_isp == start, "R5", new_isp, start);
        end else begin
            chk(wr_cnt == 2 && rd_cnt == 1, "R8", wr_cnt * 16 + rd_cnt, 33);
            chk(wr_addr[0] == start - 4 && wr_data[0] == psw_in, "R8", wr_data[0], psw_in);
            chk(wr_addr[1] == start - 8 && wr_data[1] == pc_in, "R8", wr_data[1], pc_in);
            chk(new_isp == start - 8, "R8", new_isp, start - 8);
            chk(rd_addr_s == vaddr, "R9", rd_addr_s, vaddr);
            chk(new_pc == (vaddr ^ RD_XOR), "R9", new_pc, vaddr ^ RD_XOR);
        end
        nirq_req = 0; fint_req = 0; exc_req = 0;
        @(negedge clk);
        chk(!done, "R11", {31'd0, done}, 32'd0);
        if (kind == 1) chk(ack_cnt == 0, "R12", ack_cnt, 0);
        else begin
            chk(ack_cnt == 1 && ack_fast_s == (kind == 3), "R12", ack_cnt, 1);
            if (kind == 2) chk(ack_num_s == t_num, "R12", {24'd0, ack_num_s}, {24'd0, t_num});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !ack && !mem_valid, "R1", {29'd0, done, ack, mem_valid}, 32'd0);
        rst_n = 1'b1;
        // Normal interrupt grid
        for (int fi = 0; fi < 2; fi++)
            for (int ip = 0; ip < 16; ip++)
                for (int lv = 0; lv < 16; lv++) begin
                    t_exc = 0; t_fint = 0; t_nirq = 1; t_i = fi[0]; t_u = lv[0];
                    t_ipl = ip[3:0]; t_lvl = lv[3:0]; t_num = 8'(ip * 16 + lv); t_vec = '0;
                    run_trial();
                end
        // Fast interrupt against the ceiling, normal also pending at level 15
        for (int fi = 0; fi < 2; fi++)
            for (int ip = 0; ip < 16; ip++) begin
                t_exc = 0; t_fint = 1; t_nirq = 1; t_i = fi[0]; t_u = ip[0];
                t_ipl = ip[3:0]; t_lvl = 4'hF; t_num = 8'h77; t_vec = '0;
                run_trial();
            end
        // Exceptions beat both interrupt types, regardless of I
        for (int e = 0; e < 12; e++) begin
            logic [8:0] vl [12];
            vl = '{9'd20, 9'd21, 9'd23, 9'd25, 9'd30, 9'd0, 9'hFF, 9'h100,
                   9'h1FF, 9'h180, 9'd15, 9'h13};
            t_exc = 1; t_fint = 1; t_nirq = 1; t_i = e[0]; t_u = e[1];
            t_ipl = 4'(e); t_lvl = 4'hF; t_num = 8'h42; t_vec = vl[e];
            run_trial();
        end
        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule